// File: doc/BRIEF.md
# Indirect-Addressed Host Register Port

This block is the host-facing control port of a peripheral. It has an 8-bit data bus, an active-low chip select, separate active-low read and write strobes, and a 2-bit address. The address picks one of four direct locations.

Location 0 holds a 6-bit index. Location 1 is a window onto a bank of 37 byte-wide control registers, and the stored index chooses which one. Location 2 returns a status byte that the core supplies, and a host write there raises a clear pulse for pending interrupt conditions. Location 3 is the programmed-I/O data location, which is two registers in one place. A write there fills a playback holding byte. A read there returns the capture byte that the core supplies.

The host side runs without a clock. The block samples the strobes into the core clock through two flops. Each register action happens once per access, on the edge where the sampled strobe goes back high. The whole control bank leaves the block as one flat vector, so the core can decode its fields. Register n sits in bits [8n+7:8n] of that vector.

Top module: `host_regport`

## Requirements
- R1: After reset the index is 0, all 37 control registers and the playback byte are 0x00, and no event pulse is asserted.
- R2: A write to address 0 stores din[5:0] as the index and ignores din[7:6]. A read of address 0 returns {2'b00, index}.
- R3: When the index is 0 to 36, a write to address 1 stores din in the selected control register. A read of address 1 returns that register, which also appears in bits [8n+7:8n] of ctrl_flat.
- R4: When the index is 37 to 63, a read of address 1 returns 0x00, and a write to address 1 changes no control register.
- R5: A read of address 2 returns status_in. A write to address 2 produces exactly one single-cycle status_clr pulse and changes no register.
- R6: A write to address 3 stores din in play_data and produces exactly one single-cycle play_wr pulse. A read of address 3 returns cap_data and produces exactly one single-cycle cap_rd pulse.
- R7: Each access acts once, after its strobe goes back high. A strobe given while chip select is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| addr | input | 2 | Direct register address |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data for the current address |
| status_in | input | 8 | Status byte supplied by the core |
| cap_data | input | 8 | Capture byte supplied by the core |
| status_clr | output | 1 | One-cycle pulse on a host write to status |
| play_data | output | 8 | Playback holding byte |
| play_wr | output | 1 | One-cycle pulse when play_data is written |
| cap_rd | output | 1 | One-cycle pulse after a capture-byte read |
| ctrl_flat | output | 296 | All control registers, register n in bits [8n+7:8n] |

## Verification
The hardest case to reach from the ports is an access through the data window while the index points past the bank. A stray write in that case must leave all 37 real registers untouched.

The stimulus first fills every real register with a pattern that is distinct for each register. It then sweeps the full 6-bit index range, writing a different pattern at each of the 64 index values. Finally it reads back all 64 indices. Any corruption shows up as a mismatch against the first pattern, and any out-of-range read that is not zero shows up directly.

A strobe given with chip select high, followed by a read of the target register, covers the qualification path.

// File: rtl/host_regport.sv
module host_regport #(
  parameter int NREG = 37,
  parameter int DW   = 8,
  parameter int IW   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic [1:0]         addr,
  input  logic [DW-1:0]      din,
  output logic [DW-1:0]      dout,
  input  logic [DW-1:0]      status_in,
  input  logic [DW-1:0]      cap_data,
  output logic               status_clr,
  output logic [DW-1:0]      play_data,
  output logic               play_wr,
  output logic               cap_rd,
  output logic [NREG*DW-1:0] ctrl_flat
);
  localparam logic [IW-1:0] LAST = IW'(NREG - 1);

  logic [2:0] s1, s2;
  logic wr_act, rd_act, wr_act_q, rd_act_q, wr_fire, rd_fire;
  logic [1:0] haddr;
  logic [DW-1:0] hdat;
  logic [IW-1:0] idx;
  logic [DW-1:0] regs [NREG];
  logic idx_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 3'b111;
      s2 <= 3'b111;
    end else begin
      s1 <= {cs_n, wr_n, rd_n};
      s2 <= s1;
    end

  assign wr_act  = ~s2[2] & ~s2[1];
  assign rd_act  = ~s2[2] & ~s2[0];
  assign wr_fire = wr_act_q & ~wr_act;
  assign rd_fire = rd_act_q & ~rd_act;
  assign idx_ok  = idx <= LAST;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      haddr    <= '0;
      hdat     <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (wr_act || rd_act) begin
        haddr <= addr;
        hdat  <= din;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx        <= '0;
      play_data  <= '0;
      play_wr    <= 1'b0;
      status_clr <= 1'b0;
      cap_rd     <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      play_wr    <= wr_fire && haddr == 2'd3;
      status_clr <= wr_fire && haddr == 2'd2;
      cap_rd     <= rd_fire && haddr == 2'd3;
      if (wr_fire) begin
        case (haddr)
          2'd0: idx <= hdat[IW-1:0];
          2'd1: if (idx_ok) regs[idx] <= hdat;
          2'd3: play_data <= hdat;
          default: ;
        endcase
      end
    end

  always_comb begin
    dout = '0;
    case (addr)
      2'd0: dout = DW'(idx);
      2'd1: if (idx_ok) dout = regs[idx];
      2'd2: dout = status_in;
      2'd3: dout = cap_data;
    endcase
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign ctrl_flat[g*DW +: DW] = regs[g];
  end

  assert_play_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    play_wr |=> !play_wr);
  assert_cap_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rd |=> !cap_rd);
  assert_clr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr |=> !status_clr);
  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idx > LAST) |=> $stable(ctrl_flat));
  assert_clr_keeps_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr |-> $stable(ctrl_flat) && $stable(play_data) && $stable(idx));
  assert_idx_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx)) |-> $past(wr_fire));
endmodule

// File: tb/sim_host_regport.sv
module sim_host_regport;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 37;

  logic clk = 0, rst_n = 0, cs_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] din = 0, dout, status_in = 8'h5A, cap_data = 8'hC3, play_data;
  logic status_clr, play_wr, cap_rd;
  logic [NREG*8-1:0] ctrl_flat;
  int checks = 0, errors = 0;
  int n_clr = 0, n_play = 0, n_cap = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_regport u0 (.clk, .rst_n, .cs_n, .rd_n, .wr_n, .addr, .din, .dout,
    .status_in, .cap_data, .status_clr, .play_data, .play_wr, .cap_rd, .ctrl_flat);

  always @(posedge clk) begin
    if (status_clr) n_clr++;
    if (play_wr) n_play++;
    if (cap_rd) n_cap++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d, input logic sel = 1);
    @(negedge clk); addr = a; din = d; cs_n = !sel;
    @(negedge clk); wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1;
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; cs_n = 0;
    @(negedge clk); rd_n = 0;
    repeat (3) @(negedge clk);
    d = dout;
    @(negedge clk); rd_n = 1;
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int i, input int k);
    return 8'((i * 29 + k * 71 + 17) & 8'hFF);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ctrl_flat", (ctrl_flat == '0), 1);
    chk("R1 play_data", play_data, 0);
    chk("R1 pulses", {status_clr, play_wr, cap_rd}, 0);
    hread(2'd0, rv); chk("R1 index", rv, 0);
    hread(2'd1, rv); chk("R1 reg0", rv, 0);

    hwrite(2'd0, 8'hE9); hread(2'd0, rv); chk("R2 upper bits dropped", rv, 8'h29);
    hwrite(2'd0, 8'h3F); hread(2'd0, rv); chk("R2 index 63", rv, 8'h3F);

    for (int i = 0; i < NREG; i++) begin
      hwrite(2'd0, 8'(i)); hwrite(2'd1, pat(i, 0));
    end
    for (int i = 0; i < 64; i++) begin
      hwrite(2'd0, 8'(i)); hwrite(2'd1, pat(i, 1));
      if (i < NREG) begin hwrite(2'd1, pat(i, 0)); end
    end
    for (int i = 0; i < 64; i++) begin
      hwrite(2'd0, 8'(i)); hread(2'd1, rv);
      if (i < NREG) chk("R3 readback", rv, pat(i, 0));
      else chk("R4 out-of-range read", rv, 0);
    end
    for (int i = 0; i < NREG; i++)
      chk("R3 ctrl_flat field", ctrl_flat[i*8 +: 8], pat(i, 0));

    hwrite(2'd0, 8'd5);
    hwrite(2'd1, 8'hAA, 0);
    hread(2'd1, rv); chk("R7 write without select ignored", rv, pat(5, 0));
    chk("R7 no pulses while idle", n_clr + n_play + n_cap, 0);

    hread(2'd2, rv); chk("R5 status read", rv, 8'h5A);
    status_in = 8'h81;
    hread(2'd2, rv); chk("R5 status read 2", rv, 8'h81);
    hwrite(2'd2, 8'hFF); chk("R5 one clear pulse", n_clr, 1);
    hread(2'd1, rv); chk("R5 status write keeps reg", rv, pat(5, 0));
    hread(2'd0, rv); chk("R5 status write keeps index", rv, 5);

    hwrite(2'd3, 8'h77); chk("R6 play byte", play_data, 8'h77); chk("R6 one play pulse", n_play, 1);
    hwrite(2'd3, 8'h12); chk("R6 play byte 2", play_data, 8'h12); chk("R7 once per access", n_play, 2);
    hread(2'd3, rv); chk("R6 capture read", rv, 8'hC3); chk("R6 one cap pulse", n_cap, 1);
    chk("R6 read keeps play byte", play_data, 8'h12);
    chk("R5 no stray clear", n_clr, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule